// File: doc/BRIEF.md
# I2C Master Serial Clock and Data Timing Generator

This block produces the serial clock waveform of an I2C master from the system clock and marks when the master may change the data line. Three 8-bit settings control it: the clock-high length, the clock-low length and the data hold delay. The high and low phases are set in steps of four system clocks. The point at which data may change is a separate delay, counted from every falling edge of the serial clock. The hold delay is clamped so that data always settles before the next rising edge.

The surrounding byte engine asserts `bit_req` when it has a data bit waiting. The block replies with a one-cycle `sda_change` pulse at the programmed point in the low phase. At every clock rising edge it gives a one-cycle `scl_sample` pulse, which the engine uses to capture the line. New settings are loaded with `cfg_wr` into holding registers. They reach the active copy only when a low phase starts, so a phase already running is never shortened.

Top module: `i2c_scl_timer`

## Requirements
- R1: During and after reset, and while disabled, `scl_pull_low` is 0 (SCL released) and `sda_change` and `scl_sample` are 0.
- R2: When `enable` is seen high in the idle state, `scl_pull_low` is 1 on the next cycle. That cycle starts a low phase.
- R3: A low phase keeps `scl_pull_low` at 1 for exactly 4×L+2 system clocks, where L is the active low setting.
- R4: A high phase keeps `scl_pull_low` at 0 for exactly 4×H+2 system clocks, where H is the active high setting. One SCL period is therefore 4×(L+H)+4 clocks.
- R5: Reset values of the holding registers are high 0x3F, low 0x3F and hold 0x01. Enabling without any write therefore gives a 254-clock low phase, a 254-clock high phase, and a `sda_change` in low-phase cycle 3.
- R6: Number the low-phase cycles from 0, where cycle 0 is the first cycle of the low phase. `sda_change` pulses once, in cycle D+2, where D is the active hold setting. It only pulses while SCL is pulled low.
- R7: When D+2 exceeds 4×L, the pulse is clamped to cycle 4×L. This is at least one cycle before the rising edge (for L=0 that is cycle 0).
- R8: `sda_change` is produced only in cycles where `bit_req` is 1. With `bit_req` at 0 for a whole low phase, no pulse occurs.
- R9: `scl_sample` is 1 for exactly one cycle, which is the first cycle of each high phase.
- R10: A `cfg_wr` pulse captures `high_val`, `low_val` and `hold_val`. The captured values take effect from the start of the next low phase. A phase already in progress keeps its length.
- R11: When `enable` is seen low, SCL is released on the next cycle and no strobes are produced while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the generator when 1 |
| cfg_wr | input | 1 | Captures the three settings into holding registers |
| high_val | input | 8 | SCL high setting H |
| low_val | input | 8 | SCL low setting L |
| hold_val | input | 8 | SDA hold setting D |
| bit_req | input | 1 | A data bit is waiting to be shifted out |
| scl_pull_low | output | 1 | 1 drives SCL low, 0 releases it (open-drain) |
| sda_change | output | 1 | One-cycle pulse: SDA may change now |
| scl_sample | output | 1 | One-cycle pulse at the SCL rising edge |

## Verification
The assertions check four things on every cycle:
- Sample pulses last one cycle and fall on the first released cycle.
- Data-change pulses occur only while SCL is low and a bit is requested.
- A low phase never starts without `enable`.
- Disabling leaves the outputs quiet on the following cycle.

Phase lengths, the exact hold position with its clamp, the reset defaults and the deferred loading of written settings depend on the programmed values. Only the bench's directed scenarios measure these, by counting cycles against values computed from the requirements.

// File: rtl/i2c_tmr_pkg.sv
// Package: shared phase encoding and width helpers for the SCL timing generator.
// Assumes settings are CFG_W bits wide; phase counters need CFG_W+2 bits.
package i2c_tmr_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_t;
endpackage

// File: rtl/i2c_tmr_cfg.sv
// Module: holding and active copies of the three timing settings.
// Holding registers take a write at any time; active copies load from them
// only when the sequencer signals the start of a low phase.
module i2c_tmr_cfg #(
    parameter int CFG_W    = 8,
    parameter int HIGH_RST = 8'h3F,
    parameter int LOW_RST  = 8'h3F,
    parameter int HOLD_RST = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] high_in,
    input  logic [CFG_W-1:0] low_in,
    input  logic [CFG_W-1:0] hold_in,
    input  logic             load,
    output logic [CFG_W-1:0] act_high,
    output logic [CFG_W-1:0] act_low,
    output logic [CFG_W-1:0] act_hold
);
    logic [CFG_W-1:0] pend_high, pend_low, pend_hold;

    // Capture software-side values into the holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_high <= CFG_W'(HIGH_RST);
            pend_low  <= CFG_W'(LOW_RST);
            pend_hold <= CFG_W'(HOLD_RST);
        end else if (wr) begin
            pend_high <= high_in;
            pend_low  <= low_in;
            pend_hold <= hold_in;
        end
    end

    // Move holding values to the active set at a low-phase start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_high <= CFG_W'(HIGH_RST);
            act_low  <= CFG_W'(LOW_RST);
            act_hold <= CFG_W'(HOLD_RST);
        end else if (load) begin
            act_high <= pend_high;
            act_low  <= pend_low;
            act_hold <= pend_hold;
        end
    end
endmodule

// File: rtl/i2c_tmr_seq.sv
// Module: phase sequencer. Walks IDLE -> LOW -> HIGH -> LOW ... and counts
// system clocks within the phase. Low lasts 4*L+2, high lasts 4*H+2 clocks.
// Assumes the active settings are stable during a phase (loaded on entry).
module i2c_tmr_seq
    import i2c_tmr_pkg::*;
#(
    parameter int CFG_W = 8,
    localparam int CNT_W = CFG_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CFG_W-1:0] act_high,
    input  logic [CFG_W-1:0] act_low,
    output phase_t           phase,
    output logic [CNT_W-1:0] cnt,
    output logic             load
);
    logic [CNT_W-1:0] low_last, high_last;

    // Final count index of each phase.
    always_comb begin
        low_last  = {act_low, 2'b00} + CNT_W'(1);
        high_last = {act_high, 2'b00} + CNT_W'(1);
    end

    // Request an active-settings load on every entry into a low phase.
    always_comb begin
        load = enable && ((phase == PH_IDLE) ||
                          (phase == PH_HIGH && cnt == high_last));
    end

    // Phase register and in-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    phase <= PH_LOW;
                    cnt   <= '0;
                end
                PH_LOW: begin
                    if (cnt == low_last) begin
                        phase <= PH_HIGH;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (cnt == high_last) begin
                        phase <= PH_LOW;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/i2c_tmr_strobe.sv
// Module: output decode. Drives SCL low in the low phase, pulses the sample
// strobe on the first high cycle, and pulses the data-change strobe at low
// cycle min(D+2, 4*L) when a bit is requested.
module i2c_tmr_strobe
    import i2c_tmr_pkg::*;
#(
    parameter int CFG_W = 8,
    localparam int CNT_W = CFG_W + 2
) (
    input  phase_t           phase,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CFG_W-1:0] act_low,
    input  logic [CFG_W-1:0] act_hold,
    input  logic             bit_req,
    output logic             scl_pull_low,
    output logic             sda_change,
    output logic             scl_sample
);
    logic [CNT_W-1:0] hold_tgt, hold_lim, hold_eff;

    // Clamp the hold point so it ends before the rising edge.
    always_comb begin
        hold_tgt = {2'b00, act_hold} + CNT_W'(2);
        hold_lim = {act_low, 2'b00};
        hold_eff = (hold_tgt > hold_lim) ? hold_lim : hold_tgt;
    end

    // Decode line drive and strobes from phase and count.
    always_comb begin
        scl_pull_low = (phase == PH_LOW);
        scl_sample   = (phase == PH_HIGH) && (cnt == '0);
        sda_change   = (phase == PH_LOW) && (cnt == hold_eff) && bit_req;
    end
endmodule

// File: rtl/i2c_scl_timer.sv
// Module: top of the I2C master SCL/SDA timing generator.
// Connects settings storage, phase sequencer and output decode.
// Assumes a single system clock and synchronous active-low reset.
module i2c_scl_timer
    import i2c_tmr_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] high_val,
    input  logic [CFG_W-1:0] low_val,
    input  logic [CFG_W-1:0] hold_val,
    input  logic             bit_req,
    output logic             scl_pull_low,
    output logic             sda_change,
    output logic             scl_sample
);
    localparam int CNT_W = CFG_W + 2;

    logic [CFG_W-1:0] act_high, act_low, act_hold;
    logic [CNT_W-1:0] cnt;
    logic             load;
    phase_t           phase;

    i2c_tmr_cfg #(.CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
        .high_in(high_val), .low_in(low_val), .hold_in(hold_val),
        .load(load),
        .act_high(act_high), .act_low(act_low), .act_hold(act_hold)
    );

    i2c_tmr_seq #(.CFG_W(CFG_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .act_high(act_high), .act_low(act_low),
        .phase(phase), .cnt(cnt), .load(load)
    );

    i2c_tmr_strobe #(.CFG_W(CFG_W)) u_strobe (
        .phase(phase), .cnt(cnt), .act_low(act_low), .act_hold(act_hold),
        .bit_req(bit_req),
        .scl_pull_low(scl_pull_low), .sda_change(sda_change),
        .scl_sample(scl_sample)
    );
endmodule

// File: rtl/i2c_scl_timer_checker.sv
// Module: cycle-level properties of the timing generator's ports.
// Attached to every instance of the top through the bind below.
module i2c_scl_timer_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic bit_req,
    input logic scl_pull_low,
    input logic sda_change,
    input logic scl_sample
);
    assert_sample_at_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        scl_sample |-> (!scl_pull_low && $past(scl_pull_low)));

    assert_sample_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        scl_sample |=> !scl_sample);

    assert_sda_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change |-> scl_pull_low);

    assert_sda_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change |-> bit_req);

    assert_start_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_low) |-> $past(enable));

    assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_pull_low && !sda_change && !scl_sample));
endmodule

bind i2c_scl_timer i2c_scl_timer_checker u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bit_req(bit_req),
    .scl_pull_low(scl_pull_low), .sda_change(sda_change),
    .scl_sample(scl_sample)
);

// File: tb/i2c_scl_timer_bench.sv
`timescale 1ns/1ps
// Directed bench: each task drives one scenario and checks its own results.
module i2c_scl_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] high_val = '0;
    logic [7:0] low_val = '0;
    logic [7:0] hold_val = '0;
    logic       bit_req = 1'b0;
    logic       scl_pull_low, sda_change, scl_sample;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    i2c_scl_timer u_i2c_scl_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
        .high_val(high_val), .low_val(low_val), .hold_val(hold_val),
        .bit_req(bit_req), .scl_pull_low(scl_pull_low),
        .sda_change(sda_change), .scl_sample(scl_sample)
    );

    task automatic check_eq(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(int h, int l, int d);
        high_val = 8'(h); low_val = 8'(l); hold_val = 8'(d); cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Start at the negedge of low-cycle 0 (chained) or wait for a falling SCL edge.
    task automatic measure(input bit chained, output int lo, output int hi,
                           output int sda_idx, output int sda_cnt, output int smp_bad);
        logic prev;
        prev = scl_pull_low;
        if (!chained) begin
            forever begin
                @(negedge clk);
                if (scl_pull_low && !prev) break;
                prev = scl_pull_low;
            end
        end
        lo = 0; hi = 0; sda_idx = -1; sda_cnt = 0; smp_bad = 0;
        while (scl_pull_low) begin
            if (sda_change) begin
                if (sda_idx < 0) sda_idx = lo;
                sda_cnt++;
            end
            if (scl_sample) smp_bad++;
            lo++;
            @(negedge clk);
        end
        if (!scl_sample) smp_bad++;
        while (!scl_pull_low) begin
            if (hi > 0 && scl_sample) smp_bad++;
            if (sda_change) smp_bad++;
            hi++;
            @(negedge clk);
        end
    endtask

    task automatic stop_gen();
        enable = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            check_eq("R11", "released after disable", scl_pull_low, 0);
            check_eq("R11", "no strobes when off", sda_change | scl_sample, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check_eq("R1", "scl released in reset", scl_pull_low, 0);
        check_eq("R1", "strobes quiet in reset", sda_change | scl_sample, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R1", "scl released idle", scl_pull_low, 0);
        check_eq("R1", "strobes quiet idle", sda_change | scl_sample, 0);
    endtask

    task automatic t_defaults();
        int lo, hi, si, sc, sb;
        bit_req = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        check_eq("R2", "low phase one cycle after enable", scl_pull_low, 1);
        measure(1'b1, lo, hi, si, sc, sb);
        check_eq("R5", "default low length", lo, 254);
        check_eq("R5", "default high length", hi, 254);
        check_eq("R5", "default hold index", si, 3);
        check_eq("R9", "sample strobe placement", sb, 0);
        stop_gen();
    endtask

    task automatic t_run(string req, int h, int l, int d, int e_si);
        int lo, hi, si, sc, sb;
        write_cfg(h, l, d);
        enable = 1'b1;
        @(negedge clk);
        measure(1'b1, lo, hi, si, sc, sb);
        check_eq("R3", "low length", lo, 4*l + 2);
        check_eq("R4", "high length", hi, 4*h + 2);
        check_eq("R4", "period", lo + hi, 4*(l + h) + 4);
        check_eq(req, "hold index", si, e_si);
        check_eq("R6", "one data strobe per low phase", sc, 1);
        check_eq("R9", "sample strobe placement", sb, 0);
        stop_gen();
    endtask

    task automatic t_noreq();
        int lo, hi, si, sc, sb;
        write_cfg(1, 2, 4);
        bit_req = 1'b0;
        enable = 1'b1;
        @(negedge clk);
        measure(1'b1, lo, hi, si, sc, sb);
        check_eq("R8", "no data strobe without request", sc, 0);
        check_eq("R8", "low length unchanged", lo, 10);
        bit_req = 1'b1;
        stop_gen();
    endtask

    task automatic t_midwrite();
        int lo, hi, si, sc, sb;
        write_cfg(1, 2, 4);
        enable = 1'b1;
        @(negedge clk);
        measure(1'b1, lo, hi, si, sc, sb);
        // now in low-cycle 0 of the second period; write during it
        write_cfg(3, 3, 5);
        measure(1'b1, lo, hi, si, sc, sb);
        check_eq("R10", "running low not changed", lo + 1, 10);
        check_eq("R10", "running high not changed", hi, 6);
        measure(1'b1, lo, hi, si, sc, sb);
        check_eq("R10", "next low uses new value", lo, 14);
        check_eq("R10", "next high uses new value", hi, 14);
        check_eq("R10", "next hold uses new value", si, 7);
        stop_gen();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_defaults();
        t_run("R6", 1, 2, 4, 6);
        t_run("R7", 2, 1, 200, 4);
        t_run("R7", 0, 0, 1, 0);
        t_noreq();
        t_midwrite();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule